// File: doc/BRIEF.md
# Four-Bit Universal Counter and Shift Register

This block is a small register whose operation is picked on every rising clock edge by a three-bit mode code. The register can:

- load a parallel word,
- invert every bit,
- shift in either direction,
- count up or down modulo 2^WIDTH,
- clear itself, or
- hold its value.

The default width is four bits.

Two active-low enables gate counting. The "parallel" enable only stops the local stage. The "trickle" enable also qualifies the terminal-count output, so several stages can be chained into a wider counter. To build such a chain, tie each stage's terminal count to the trickle enable of the stage above it, and drive the parallel enables in common. The trickle-enable pin has a second job: it is the serial input when shifting toward the top bit. A separate pin feeds the top bit when shifting toward bit 0.

The outputs are the state, its bitwise complement, and the terminal count. The terminal count is combinational from the state, the mode code and the trickle enable, so a carry or borrow reaches the next stage within the same cycle. A high master reset clears the register at once, with no clock, and overrides every other input.

Top module: `ucsr_stage`

## Requirements
- R1: While `mrst` is high, `q` is all zeros at once, without waiting for a clock edge, whatever the other inputs do. In that state `tc` obeys the same per-mode rule as for any all-zero state.
- R2: Mode 3'b000 loads `preset` into `q` at the clock edge, and `tc` is 0 throughout that mode.
- R3: Mode 3'b001 replaces `q` with `~q` at the clock edge, and `tc` is 0 throughout that mode.
- R4: Mode 3'b010 shifts toward bit 0: bit i takes bit i+1 and the top bit takes `ser_dn`. Mode 3'b011 shifts toward the top: bit i+1 takes bit i and bit 0 takes `en_trk_n`.
- R5: Mode 3'b110 adds 1 and mode 3'b100 subtracts 1, modulo 2^WIDTH, with `q[0]` as the least significant bit. This happens only when `en_par_n` and `en_trk_n` are both 0. The count wraps from all ones to zero and from zero to all ones.
- R6: In modes 3'b100 and 3'b110, if either enable is 1, `q` does not change.
- R7: Mode 3'b101 sets `q` to zero at the clock edge and mode 3'b111 keeps `q` unchanged. In both modes `tc` is 1.
- R8: In modes 3'b010 and 3'b011, `tc` equals the current top bit `q[WIDTH-1]`.
- R9: In mode 3'b100, `tc` is 0 exactly when `en_trk_n` is 0 and `q` is zero. In mode 3'b110, `tc` is 0 exactly when `en_trk_n` is 0 and `q` is all ones. In both modes `tc` changes in the same cycle as its inputs, and `en_par_n` has no influence on it.
- R10: `q_n` is always the bitwise inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| mode | input | 3 | Operation code |
| preset | input | WIDTH | Parallel load data |
| en_par_n | input | 1 | Local count enable, active low |
| en_trk_n | input | 1 | Cascade count enable, active low; serial input for up-shift |
| ser_dn | input | 1 | Serial input for down-shift |
| q | output | WIDTH | Register state |
| q_n | output | WIDTH | Complement of state |
| tc | output | 1 | Terminal count / top-bit mirror |

## Verification
The bench sweeps every mode from every starting value under all eight enable and serial-input combinations. This exposes a design that lets `en_par_n` gate `tc`. It also exposes one that swaps the two serial sources, or shifts in the wrong direction.

Both wrap points are hit, so a counter that saturates at 15 or at 0 is caught. A two-stage chain is run through all 256 values, up and then down. A stage whose borrow or carry arrives one cycle late would skip or repeat a value there.

The reset is raised in the middle of a clock period and must clear `q` before the next edge. A reset implemented synchronously would leave the old value visible until that edge.

// File: rtl/ucsr_pkg.sv
`timescale 1ns/1ps
package ucsr_pkg;
   typedef enum logic [2:0] {
      M_LOAD = 3'b000,
      M_INV  = 3'b001,
      M_SHDN = 3'b010,
      M_SHUP = 3'b011,
      M_CDN  = 3'b100,
      M_CLR  = 3'b101,
      M_CUP  = 3'b110,
      M_HOLD = 3'b111
   } ucsr_mode_e;
endpackage

// File: rtl/ucsr_next.sv
`timescale 1ns/1ps
module ucsr_next
   import ucsr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  ucsr_mode_e       mode,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] preset,
   input  logic             en_par_n,
   input  logic             en_trk_n,
   input  logic             ser_dn,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic             cnt_go;
   logic [WIDTH-1:0] sh_dn;
   logic [WIDTH-1:0] sh_up;

   assign cnt_go = ~en_par_n & ~en_trk_n;

   // shift wiring, one bit per generate iteration
   for (genvar i = 0; i < WIDTH; i++) begin : g_sh
      if (i == WIDTH - 1) begin : g_top
         assign sh_dn[i] = ser_dn;
      end else begin : g_mid
         assign sh_dn[i] = cur[i+1];
      end
      if (i == 0) begin : g_bot
         assign sh_up[i] = en_trk_n;
      end else begin : g_up
         assign sh_up[i] = cur[i-1];
      end
   end

   always_comb begin
      case (mode)
         M_LOAD:  nxt = preset;
         M_INV:   nxt = ~cur;
         M_SHDN:  nxt = sh_dn;
         M_SHUP:  nxt = sh_up;
         M_CDN:   nxt = cnt_go ? cur - ONE : cur;
         M_CLR:   nxt = '0;
         M_CUP:   nxt = cnt_go ? cur + ONE : cur;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/ucsr_tc.sv
`timescale 1ns/1ps
module ucsr_tc
   import ucsr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  ucsr_mode_e       mode,
   input  logic [WIDTH-1:0] cur,
   input  logic             en_trk_n,
   output logic             tc
);
   logic at_zero;
   logic at_full;

   assign at_zero = (cur == '0);
   assign at_full = (cur == '1);

   always_comb begin
      case (mode)
         M_LOAD, M_INV:  tc = 1'b0;
         M_SHDN, M_SHUP: tc = cur[WIDTH-1];
         M_CDN:          tc = ~(~en_trk_n & at_zero);
         M_CUP:          tc = ~(~en_trk_n & at_full);
         default:        tc = 1'b1;
      endcase
   end

   // R9: the carry/borrow never fires while the cascade enable is off
   always_comb begin
      if ((mode == M_CDN || mode == M_CUP) && en_trk_n)
         AST_TC_TRK_OFF: assert (tc == 1'b1); // R9
   end
endmodule

// File: rtl/ucsr_stage.sv
`timescale 1ns/1ps
module ucsr_stage
   import ucsr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic [2:0]       mode,
   input  logic [WIDTH-1:0] preset,
   input  logic             en_par_n,
   input  logic             en_trk_n,
   input  logic             ser_dn,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_n,
   output logic             tc
);
   localparam logic [WIDTH-1:0] ALL1 = '1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ucsr_stage: WIDTH must be at least 2");
   end

   ucsr_mode_e       md;
   logic [WIDTH-1:0] state;
   logic [WIDTH-1:0] nxt;

   assign md = ucsr_mode_e'(mode);

   ucsr_next #(.WIDTH(WIDTH)) u_next (
      .mode     (md),
      .cur      (state),
      .preset   (preset),
      .en_par_n (en_par_n),
      .en_trk_n (en_trk_n),
      .ser_dn   (ser_dn),
      .nxt      (nxt)
   );

   ucsr_tc #(.WIDTH(WIDTH)) u_tc (
      .mode     (md),
      .cur      (state),
      .en_trk_n (en_trk_n),
      .tc       (tc)
   );

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) state <= '0;
      else      state <= nxt;
   end

   assign q = state;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
      assign q_n[i] = ~state[i];
   end

   AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (mrst)
      md == M_LOAD |=> q == $past(preset)); // R2
   AST_INVERT_FLIPS: assert property (@(posedge clk) disable iff (mrst)
      md == M_INV |=> q == ~$past(q)); // R3
   AST_SHDN_TOP_IN: assert property (@(posedge clk) disable iff (mrst)
      md == M_SHDN |=> q[WIDTH-1] == $past(ser_dn)); // R4
   AST_UP_WRAP: assert property (@(posedge clk) disable iff (mrst)
      (md == M_CUP && !en_par_n && !en_trk_n && q == ALL1) |=> q == '0); // R5
   AST_COUNT_GATED: assert property (@(posedge clk) disable iff (mrst)
      ((md == M_CUP || md == M_CDN) && (en_par_n || en_trk_n)) |=> $stable(q)); // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (mrst)
      md == M_CLR |=> q == '0); // R7
   AST_SHIFT_TC_TOP: assert property (@(posedge clk) disable iff (mrst)
      (md == M_SHDN || md == M_SHUP) |-> tc == q[WIDTH-1]); // R8
endmodule

// File: tb/sim_ucsr_stage.sv
`timescale 1ns/1ps
module sim_ucsr_stage;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         mrst = 1'b1;
   logic [2:0]   mode = 3'b000;
   logic [W-1:0] preset = '0;
   logic         en_par_n = 1'b0, en_trk_n = 1'b0, ser_dn = 1'b0;
   logic [W-1:0] q, q_n;
   logic         tc;

   logic [2:0]   c_mode = 3'b111;
   logic         c_trk = 1'b0;
   logic [W-1:0] lo_q, lo_qn, hi_q, hi_qn;
   logic         lo_tc, hi_tc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [W-1:0] exp_q;

   always #2.5 clk = ~clk;

   ucsr_stage #(.WIDTH(W)) u0 (
      .clk(clk), .mrst(mrst), .mode(mode), .preset(preset),
      .en_par_n(en_par_n), .en_trk_n(en_trk_n), .ser_dn(ser_dn),
      .q(q), .q_n(q_n), .tc(tc));

   ucsr_stage #(.WIDTH(W)) u1 (
      .clk(clk), .mrst(mrst), .mode(c_mode), .preset('0),
      .en_par_n(1'b0), .en_trk_n(c_trk), .ser_dn(1'b0),
      .q(lo_q), .q_n(lo_qn), .tc(lo_tc));

   ucsr_stage #(.WIDTH(W)) u2 (
      .clk(clk), .mrst(mrst), .mode(c_mode), .preset('0),
      .en_par_n(1'b0), .en_trk_n(lo_tc), .ser_dn(1'b0),
      .q(hi_q), .q_n(hi_qn), .tc(hi_tc));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] ref_next(input logic [2:0] m, input logic [W-1:0] c,
         input logic [W-1:0] p, input logic pn, input logic tn, input logic sd);
      case (m)
         3'b000: return p;
         3'b001: return ~c;
         3'b010: return {sd, c[W-1:1]};
         3'b011: return {c[W-2:0], tn};
         3'b100: return (!pn && !tn) ? W'((c + 15) % 16) : c;
         3'b101: return '0;
         3'b110: return (!pn && !tn) ? W'((c + 1) % 16) : c;
         default: return c;
      endcase
   endfunction

   function automatic logic ref_tc(input logic [2:0] m, input logic [W-1:0] c, input logic tn);
      case (m)
         3'b000, 3'b001: return 1'b0;
         3'b010, 3'b011: return c[W-1];
         3'b100: return !(tn == 1'b0 && c == 0);
         3'b110: return !(tn == 1'b0 && c == 15);
         default: return 1'b1;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'b000: return "R2";
         3'b001: return "R3";
         3'b010, 3'b011: return "R4";
         3'b100, 3'b110: return "R5/R6";
         default: return "R7";
      endcase
   endfunction

   // drive at negedge, check tc combinationally, then q after the edge
   task automatic step(input logic [2:0] m, input logic [W-1:0] p,
         input logic pn, input logic tn, input logic sd);
      @(negedge clk);
      mode = m; preset = p; en_par_n = pn; en_trk_n = tn; ser_dn = sd;
      #1;
      if (m == 3'b010 || m == 3'b011)
         chk(tc == ref_tc(m, exp_q, tn), "R8 tc", int'(tc), int'(ref_tc(m, exp_q, tn)));
      else
         chk(tc == ref_tc(m, exp_q, tn), "R9 tc", int'(tc), int'(ref_tc(m, exp_q, tn)));
      exp_q = ref_next(m, exp_q, p, pn, tn, sd);
      @(posedge clk);
      #1;
      chk(q == exp_q, req_of(m), int'(q), int'(exp_q));
      chk(q_n == ~exp_q, "R10 q_n", int'(q_n), int'(~exp_q));
   endtask

   initial begin
      #1;
      chk(q == 0, "R1 reset q", int'(q), 0);
      chk(q_n == 4'hF, "R10 reset q_n", int'(q_n), 15);
      chk(tc == 1'b0, "R1 reset tc load mode", int'(tc), 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      mrst = 1'b0;
      exp_q = '0;

      // full sweep: every start value, mode, enable/serial combination
      for (int s = 0; s < 16; s++)
         for (int m = 0; m < 8; m++)
            for (int c = 0; c < 8; c++) begin
               step(3'b000, W'(s), 1'b0, 1'b0, 1'b0);
               step(3'(m), W'(~s), c[2], c[1], c[0]);
            end

      // R5 wrap points
      step(3'b000, 4'hF, 1'b0, 1'b0, 1'b0);
      step(3'b110, 4'h0, 1'b0, 1'b0, 1'b0);
      chk(q == 0, "R5 wrap 15->0", int'(q), 0);
      step(3'b100, 4'h0, 1'b0, 1'b0, 1'b0);
      chk(q == 15, "R5 wrap 0->15", int'(q), 15);
      // R9 en_par_n does not affect tc
      @(negedge clk);
      mode = 3'b110; en_par_n = 1'b1; en_trk_n = 1'b0;
      #1;
      chk(tc == 1'b0, "R9 tc ignores en_par_n", int'(tc), 0);

      // R1 mid-cycle reset
      step(3'b000, 4'hA, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      mode = 3'b100; en_par_n = 1'b0; en_trk_n = 1'b0;
      @(posedge clk);
      #1;
      exp_q = 4'h9;
      chk(q == exp_q, "R5 down before reset", int'(q), int'(exp_q));
      #1;
      mrst = 1'b1;
      #0.5;
      chk(q == 0, "R1 async clear mid-cycle", int'(q), 0);
      chk(tc == 1'b0, "R1 tc count-down at zero", int'(tc), 0);
      mode = 3'b110;
      #0.5;
      chk(tc == 1'b1, "R1 tc count-up at zero", int'(tc), 1);
      mode = 3'b000; preset = 4'h5;
      @(posedge clk);
      #1;
      chk(q == 0, "R1 reset overrides load", int'(q), 0);
      @(negedge clk);
      mrst = 1'b0;
      exp_q = '0;

      // two-stage cascade up through 256 values
      @(negedge clk);
      c_trk = 1'b0; c_mode = 3'b110;
      for (int i = 1; i <= 256; i++) begin
         @(posedge clk);
         #1;
         chk({hi_q, lo_q} == 8'(i % 256), "R9 cascade up", int'({hi_q, lo_q}), i % 256);
      end
      // trickle disable holds the whole chain
      @(negedge clk);
      c_trk = 1'b1;
      @(posedge clk);
      #1;
      chk({hi_q, lo_q} == 8'd0, "R6 cascade hold", int'({hi_q, lo_q}), 0);
      @(negedge clk);
      c_trk = 1'b0; c_mode = 3'b100;
      for (int i = 1; i <= 256; i++) begin
         @(posedge clk);
         #1;
         chk({hi_q, lo_q} == 8'((256 - i) % 256), "R9 cascade down",
             int'({hi_q, lo_q}), (256 - i) % 256);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule